// File: doc/BRIEF.md
# SMBus quick command engine

This block runs a zero-length SMBus quick transaction on its own by driving the open-drain SDA and SCL lines directly. One transaction has four parts: a START, an address byte made of a 7-bit target address and a read/write bit, one acknowledge slot, and a STOP. No data bytes follow. The block is used to find out whether a target is present. A pulse on `start_i` launches a transaction. When it ends, a one-cycle `done_o` pulse reports the outcome as ACK, NACK or stuck bus.

The drive outputs are active high: a 1 pulls the line low and a 0 releases it. The line levels read back on `sda_in_i` and `scl_in_i` pass through a two-stage synchronizer. All bus timing is a count of system-clock cycles. The counts are derived from the `CLK_HZ` parameter, and `fast_i` selects between a standard-mode set and a fast-mode set. Every wait for a released line to read back high is guarded by a timeout of `TIMEOUT_CYC` cycles. The default timeout is about 36 ms.

Top module: `quick_probe_engine`

## Requirements
- R1: After reset, both drive outputs are 0, `busy_o` is 0, `done_o` is 0 and `result_o` is 0 (no result).
- R2: After a start, both lines are released. The engine then waits until SDA and SCL both read high, and waits at least one bus-free time (4700 ns standard, 1300 ns fast) before it pulls SDA low.
- R3: The START condition pulls SDA low while SCL is released. SCL is pulled low exactly one START-hold time later (4000 ns standard, 600 ns fast, as whole clock cycles).
- R4: The address byte is {addr_i, rw_i} and is sent most significant bit first. A 1 bit releases SDA and a 0 bit drives it. SDA changes only while SCL is driven low, at the midpoint of the low period.
- R5: Every SCL low period lasts twice floor(low/2) cycles, where low is 4700 ns standard or 1300 ns fast. After each SCL release the engine waits for SCL to read back high, so a stretching target is honoured. It then holds SCL released for at least the high time (4000 ns or 600 ns).
- R6: In the acknowledge slot SDA is released. If SDA reads low while SCL is high, the result is ACK (code 1). If it reads high, the result is NACK (code 2).
- R7: The STOP drives both lines low for one low period and then releases SCL. After SCL reads high, the engine waits at least the STOP setup time (4000 ns or 600 ns) and releases SDA. It then waits at least one bus-free time before `done_o`.
- R8: If any wait for a line to read high lasts `TIMEOUT_CYC` cycles, the transaction ends with result STUCK (code 3) and both lines released. Whenever `busy_o` is 0, both drives are 0.
- R9: A start pulse while `busy_o` is 1 is ignored. The running transaction keeps its address and ends with a single `done_o`.
- R10: `done_o` is high for exactly one cycle and `busy_o` falls in that same cycle. `result_o` carries a nonzero code with it and holds that code until the next `done_o`.
- R11: When `fast_i` is 1 at the start, the fast-mode timing set is used for the whole transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch a transaction; sampled only while idle |
| addr_i | input | 7 | Target address |
| rw_i | input | 1 | Read/write bit placed after the address |
| fast_i | input | 1 | 1 selects fast-mode timing |
| sda_in_i | input | 1 | Level read back from the SDA line |
| scl_in_i | input | 1 | Level read back from the SCL line |
| sda_drive_o | output | 1 | 1 pulls SDA low |
| scl_drive_o | output | 1 | 1 pulls SCL low |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| result_o | output | 2 | 0 none, 1 ACK, 2 NACK, 3 stuck bus |

## Verification
The assertions are checked on every cycle and cover the handshake around each transaction:
- the lines are released whenever the engine is idle;
- `done_o` lasts one cycle, coincides with `busy_o` falling and carries a nonzero, held result;
- `busy_o` never rises without a start;
- SDA is pulled low with SCL released only while SCL reads high.

Only the bench scenarios can show the timing and the protocol content:
- the exact START-hold and SCL-low cycle counts, the minimum high, setup and bus-free times, and the captured address byte;
- ACK versus NACK, and clock stretching by a target model;
- a timeout on a line held low before and during a transaction, and recovery afterwards.

// File: rtl/qpe_pkg.sv
package qpe_pkg;

    typedef enum logic [1:0] {
        RES_NONE  = 2'd0,
        RES_ACK   = 2'd1,
        RES_NACK  = 2'd2,
        RES_STUCK = 2'd3
    } qpe_result_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FREE_WAIT,
        S_BUF,
        S_HOLD,
        S_LO1,
        S_LO2,
        S_RISE,
        S_HIGH,
        S_STOP_LO,
        S_STOP_RISE,
        S_STOP_SU,
        S_STOP_BUF
    } qpe_state_e;

    typedef struct packed {
        logic [31:0] hold;
        logic [31:0] setup;
        logic [31:0] half_low;
        logic [31:0] high;
        logic [31:0] free;
    } qpe_timing_t;

    function automatic logic [31:0] ns_to_cycles(int unsigned ns, int unsigned clk_hz);
        logic [63:0] c;
        c = (64'(ns) * 64'(clk_hz)) / 64'd1000000000;
        if (c == 64'd0) c = 64'd1;
        return 32'(c);
    endfunction

    function automatic qpe_timing_t timing_for(logic fast, int unsigned clk_hz);
        qpe_timing_t t;
        if (fast) begin
            t.hold     = ns_to_cycles(600, clk_hz);
            t.setup    = ns_to_cycles(600, clk_hz);
            t.half_low = ns_to_cycles(650, clk_hz);
            t.high     = ns_to_cycles(600, clk_hz);
            t.free     = ns_to_cycles(1300, clk_hz);
        end else begin
            t.hold     = ns_to_cycles(4000, clk_hz);
            t.setup    = ns_to_cycles(4000, clk_hz);
            t.half_low = ns_to_cycles(2350, clk_hz);
            t.high     = ns_to_cycles(4000, clk_hz);
            t.free     = ns_to_cycles(4700, clk_hz);
        end
        return t;
    endfunction

endpackage

// File: rtl/qpe_pin_sync.sv
module qpe_pin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic pin_i,
    output logic pin_o
);
    logic [STAGES-1:0] ff_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) ff_q <= '1;
        else       ff_q <= {ff_q[STAGES-2:0], pin_i};
    end

    assign pin_o = ff_q[STAGES-1];
endmodule

// File: rtl/qpe_timer.sv
module qpe_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)                cnt_q <= '0;
        else if (load_i)          cnt_q <= val_i;
        else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/qpe_stall_watch.sv
module qpe_stall_watch #(
    parameter int unsigned TIMEOUT_CYC = 1000
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic arm_i,
    output logic stall_o
);
    localparam int unsigned WW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [WW-1:0] LIMIT = WW'(TIMEOUT_CYC - 1);

    logic [WW-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || !arm_i) cnt_q <= '0;
        else                 cnt_q <= cnt_q + 1'b1;
    end

    assign stall_o = arm_i && (cnt_q == LIMIT);
endmodule

// File: rtl/qpe_sequencer.sv
module qpe_sequencer
    import qpe_pkg::*;
#(
    parameter int unsigned CLK_HZ = 50_000_000,
    parameter int unsigned TW     = 8
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          start_i,
    input  logic [6:0]    addr_i,
    input  logic          rw_i,
    input  logic          fast_i,
    input  logic          sda_s_i,
    input  logic          scl_s_i,
    input  logic          tmr_zero_i,
    input  logic          stall_i,
    output logic          tmr_load_o,
    output logic [TW-1:0] tmr_val_o,
    output logic          watch_arm_o,
    output logic          sda_drive_o,
    output logic          scl_drive_o,
    output logic          busy_o,
    output logic          done_o,
    output qpe_result_e   result_o
);
    localparam qpe_timing_t T_STD  = timing_for(1'b0, CLK_HZ);
    localparam qpe_timing_t T_FAST = timing_for(1'b1, CLK_HZ);
    localparam logic [3:0]  ACK_SLOT = 4'd8;

    qpe_state_e  st_q, st_n;
    logic [8:0]  sh_q, sh_n;
    logic [3:0]  idx_q, idx_n;
    logic        fast_q, fast_n, ack_q, ack_n;
    logic        sda_q, sda_n, scl_q, scl_n, done_q, done_n;
    qpe_result_e res_q, res_n;
    qpe_timing_t tm;

    assign tm = fast_q ? T_FAST : T_STD;

    always_comb begin
        st_n = st_q;   sh_n = sh_q;   idx_n = idx_q;
        fast_n = fast_q; ack_n = ack_q;
        sda_n = sda_q; scl_n = scl_q;
        done_n = 1'b0; res_n = res_q;
        tmr_load_o = 1'b0;
        tmr_val_o  = '0;
        watch_arm_o = ((st_q == S_FREE_WAIT) && !(sda_s_i && scl_s_i)) ||
                      ((st_q == S_RISE || st_q == S_STOP_RISE) && !scl_s_i);
        case (st_q)
            S_IDLE: if (start_i) begin
                st_n = S_FREE_WAIT;
                fast_n = fast_i;
                sh_n = {addr_i, rw_i, 1'b1};
                idx_n = '0;
                sda_n = 1'b0; scl_n = 1'b0;
            end
            S_FREE_WAIT: if (sda_s_i && scl_s_i) begin
                st_n = S_BUF;
                tmr_load_o = 1'b1; tmr_val_o = TW'(tm.free - 32'd1);
            end
            S_BUF: if (tmr_zero_i) begin
                st_n = S_HOLD; sda_n = 1'b1;
                tmr_load_o = 1'b1; tmr_val_o = TW'(tm.hold - 32'd1);
            end
            S_HOLD: if (tmr_zero_i) begin
                st_n = S_LO1; scl_n = 1'b1;
                tmr_load_o = 1'b1; tmr_val_o = TW'(tm.half_low - 32'd1);
            end
            S_LO1: if (tmr_zero_i) begin
                st_n = S_LO2; sda_n = !sh_q[8];
                tmr_load_o = 1'b1; tmr_val_o = TW'(tm.half_low - 32'd1);
            end
            S_LO2: if (tmr_zero_i) begin
                st_n = S_RISE; scl_n = 1'b0;
            end
            S_RISE: if (scl_s_i) begin
                st_n = S_HIGH;
                if (idx_q == ACK_SLOT) ack_n = !sda_s_i;
                tmr_load_o = 1'b1; tmr_val_o = TW'(tm.high - 32'd1);
            end
            S_HIGH: if (tmr_zero_i) begin
                scl_n = 1'b1;
                tmr_load_o = 1'b1;
                if (idx_q == ACK_SLOT) begin
                    st_n = S_STOP_LO; sda_n = 1'b1;
                    tmr_val_o = TW'((tm.half_low << 1) - 32'd1);
                end else begin
                    st_n = S_LO1;
                    idx_n = idx_q + 4'd1;
                    sh_n = {sh_q[7:0], 1'b0};
                    tmr_val_o = TW'(tm.half_low - 32'd1);
                end
            end
            S_STOP_LO: if (tmr_zero_i) begin
                st_n = S_STOP_RISE; scl_n = 1'b0;
            end
            S_STOP_RISE: if (scl_s_i) begin
                st_n = S_STOP_SU;
                tmr_load_o = 1'b1; tmr_val_o = TW'(tm.setup - 32'd1);
            end
            S_STOP_SU: if (tmr_zero_i) begin
                st_n = S_STOP_BUF; sda_n = 1'b0;
                tmr_load_o = 1'b1; tmr_val_o = TW'(tm.free - 32'd1);
            end
            S_STOP_BUF: if (tmr_zero_i) begin
                st_n = S_IDLE; done_n = 1'b1;
                res_n = ack_q ? RES_ACK : RES_NACK;
            end
            default: st_n = S_IDLE;
        endcase
        if (stall_i) begin
            st_n = S_IDLE; sda_n = 1'b0; scl_n = 1'b0;
            done_n = 1'b1; res_n = RES_STUCK;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= S_IDLE; sh_q <= '0; idx_q <= '0;
            fast_q <= 1'b0; ack_q <= 1'b0;
            sda_q <= 1'b0; scl_q <= 1'b0;
            done_q <= 1'b0; res_q <= RES_NONE;
        end else begin
            st_q <= st_n; sh_q <= sh_n; idx_q <= idx_n;
            fast_q <= fast_n; ack_q <= ack_n;
            sda_q <= sda_n; scl_q <= scl_n;
            done_q <= done_n; res_q <= res_n;
        end
    end

    assign sda_drive_o = sda_q;
    assign scl_drive_o = scl_q;
    assign busy_o      = (st_q != S_IDLE);
    assign done_o      = done_q;
    assign result_o    = res_q;
endmodule

// File: rtl/quick_probe_engine.sv
module quick_probe_engine
    import qpe_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 50_000_000,
    parameter int unsigned TIMEOUT_CYC = CLK_HZ / 28,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       start_i,
    input  logic [6:0] addr_i,
    input  logic       rw_i,
    input  logic       fast_i,
    input  logic       sda_in_i,
    input  logic       scl_in_i,
    output logic       sda_drive_o,
    output logic       scl_drive_o,
    output logic       busy_o,
    output logic       done_o,
    output logic [1:0] result_o
);
    localparam int unsigned TW = $clog2(ns_to_cycles(4700, CLK_HZ) + 2);

    logic [1:0]    pin_raw, pin_sync;
    logic          tmr_load, tmr_zero, watch_arm, stall;
    logic [TW-1:0] tmr_val;
    qpe_result_e   res;

    assign pin_raw = {scl_in_i, sda_in_i};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        qpe_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk_i (clk_i),
            .rst_i (rst_i),
            .pin_i (pin_raw[g]),
            .pin_o (pin_sync[g])
        );
    end

    qpe_timer #(.W(TW)) u_timer (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    qpe_stall_watch #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_watch (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .arm_i   (watch_arm),
        .stall_o (stall)
    );

    qpe_sequencer #(.CLK_HZ(CLK_HZ), .TW(TW)) u_seq (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .start_i     (start_i),
        .addr_i      (addr_i),
        .rw_i        (rw_i),
        .fast_i      (fast_i),
        .sda_s_i     (pin_sync[0]),
        .scl_s_i     (pin_sync[1]),
        .tmr_zero_i  (tmr_zero),
        .stall_i     (stall),
        .tmr_load_o  (tmr_load),
        .tmr_val_o   (tmr_val),
        .watch_arm_o (watch_arm),
        .sda_drive_o (sda_drive_o),
        .scl_drive_o (scl_drive_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .result_o    (res)
    );

    assign result_o = res;
endmodule

// File: rtl/qpe_checker.sv
module qpe_checker (
    input logic       clk_i,
    input logic       rst_i,
    input logic       start_i,
    input logic       scl_in_i,
    input logic       sda_drive_o,
    input logic       scl_drive_o,
    input logic       busy_o,
    input logic       done_o,
    input logic [1:0] result_o
);
    // R8: lines released whenever idle, including after a stuck-bus end
    assert_idle_released_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        !busy_o |-> (!sda_drive_o && !scl_drive_o));

    // R10: done is a single-cycle pulse
    assert_done_single_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> !done_o);

    // R10: a result code accompanies done
    assert_done_code_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> (result_o != 2'd0));

    // R10: result only changes together with done
    assert_result_hold_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        !done_o |-> $stable(result_o));

    // R10: busy ends in the done cycle
    assert_busy_end_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(busy_o) |-> done_o);

    // R9: a transaction only begins from an accepted start
    assert_busy_needs_start_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(busy_o) |-> $past(start_i));

    // R3: SDA is pulled low with SCL released only while SCL reads high
    assert_start_cond_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        ($rose(sda_drive_o) && !scl_drive_o) |-> scl_in_i);
endmodule

bind quick_probe_engine qpe_checker u_qpe_checker (.*);

// File: tb/test_quick_probe_engine.sv
module test_quick_probe_engine;

    localparam int TMO = 400;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst, start_i, rw_i, fast_i;
    logic [6:0] addr_i;
    logic sda_drive, scl_drive, busy, done;
    logic [1:0] result;
    logic sda_line, scl_line;

    // bench knobs (driven by tasks just after posedge)
    logic ack_en = 1'b0, stretch_en = 1'b0, hang_en = 1'b0;
    logic stuck_sda = 1'b0, stuck_scl = 1'b0, clr = 1'b0;
    // target model state (owned by monitor)
    logic slave_sda = 1'b0, stretch = 1'b0, hang = 1'b0;

    assign sda_line = !(sda_drive || slave_sda || stuck_sda);
    assign scl_line = !(scl_drive || stretch || hang || stuck_scl);

    quick_probe_engine #(.CLK_HZ(50_000_000), .TIMEOUT_CYC(TMO)) i_quick_probe_engine (
        .clk_i(clk), .rst_i(rst), .start_i(start_i), .addr_i(addr_i),
        .rw_i(rw_i), .fast_i(fast_i), .sda_in_i(sda_line), .scl_in_i(scl_line),
        .sda_drive_o(sda_drive), .scl_drive_o(scl_drive), .busy_o(busy),
        .done_o(done), .result_o(result)
    );

    int nchk = 0, nfail = 0;

    // ---------------- monitor and target model, at negedge ----------------
    int cyc = 0;
    int t_sda_start, hold_meas, t_low_start, low_min, low_max;
    int t_line_hi, high_min, su_meas, t_sda_rel, free_meas, done_cnt;
    int t_sdaline_rise = 0, pre_free, scnt;
    bit hold_arm, low_arm, hi_valid, width_err, in_ack, stretch_done;
    logic [7:0] cap;
    logic [3:0] bitcnt = 4'd9;
    logic psda_d = 0, pscl_d = 0, psda_l = 1, pscl_l = 1, pdone = 0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (clr) begin
            hold_arm = 0; hold_meas = -1; low_arm = 0; low_min = 99999; low_max = 0;
            hi_valid = 0; high_min = 99999; su_meas = -1; free_meas = -1;
            done_cnt = 0; width_err = 0; cap = 8'h00; bitcnt = 4'd9; in_ack = 0;
            slave_sda = 0; stretch = 0; stretch_done = 0; hang = 0; pre_free = -1;
        end else begin
            if (sda_drive && !psda_d && !scl_drive) begin
                t_sda_start = cyc; hold_arm = 1; pre_free = cyc - t_sdaline_rise;
            end
            if (scl_drive && !pscl_d) begin
                if (hold_arm) begin hold_meas = cyc - t_sda_start; hold_arm = 0; end
                if (hi_valid) begin
                    if (cyc - t_line_hi < high_min) high_min = cyc - t_line_hi;
                    hi_valid = 0;
                end
                t_low_start = cyc; low_arm = 1;
            end
            if (!scl_drive && pscl_d && low_arm) begin
                if (cyc - t_low_start < low_min) low_min = cyc - t_low_start;
                if (cyc - t_low_start > low_max) low_max = cyc - t_low_start;
                low_arm = 0;
            end
            if (scl_line && !pscl_l && busy) begin t_line_hi = cyc; hi_valid = 1; end
            if (!sda_drive && psda_d && !scl_drive && busy) begin
                su_meas = cyc - t_line_hi; t_sda_rel = cyc;
            end
            if (done) begin
                done_cnt = done_cnt + 1; free_meas = cyc - t_sda_rel;
                if (pdone) width_err = 1;
            end
            // target: START detect, capture on SCL rise, ACK after 8th bit
            if (psda_l && !sda_line && scl_line && pscl_l) begin
                bitcnt = 4'd0; in_ack = 0; cap = 8'h00;
            end else if (scl_line && !pscl_l) begin
                if (bitcnt < 4'd8) begin cap = {cap[6:0], sda_line}; bitcnt = bitcnt + 4'd1; end
            end else if (!scl_line && pscl_l) begin
                if (bitcnt == 4'd8 && !in_ack) begin slave_sda = ack_en; in_ack = 1; end
                else if (in_ack) begin slave_sda = 0; in_ack = 0; bitcnt = 4'd9; end
            end
            if (stretch) begin
                scnt = scnt - 1;
                if (scnt <= 0) stretch = 0;
            end else if (stretch_en && !stretch_done && bitcnt == 4'd3 && scl_drive) begin
                stretch = 1; scnt = 300; stretch_done = 1;
            end
            if (!hang_en) hang = 0;
            else if (bitcnt == 4'd5 && scl_drive) hang = 1;
        end
        if (sda_line && !psda_l) t_sdaline_rise = cyc;
        psda_d = sda_drive; pscl_d = scl_drive; psda_l = sda_line; pscl_l = scl_line; pdone = done;
    end

    // ---------------- helpers ----------------
    task automatic chk_eq(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_ge(string tag, int act, int lim);
        nchk++;
        if (act < lim) begin
            nfail++;
            $display("FAIL %s: actual %0d expected >= %0d", tag, act, lim);
        end
    endtask

    function automatic int cyc_of(int ns);
        return ns * 50 / 1000;
    endfunction

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic clear_stats();
        tick(); clr = 1'b1;
        tick(); clr = 1'b0;
    endtask

    task automatic launch(logic [6:0] a, logic r, logic f);
        tick(); addr_i = a; rw_i = r; fast_i = f; start_i = 1'b1;
        tick(); start_i = 1'b0;
    endtask

    task automatic wait_done(output int n);
        n = 0;
        while (done_cnt == 0 && n < 40000) begin tick(); n++; end
        if (done_cnt == 0) begin
            nchk++; nfail++;
            $display("FAIL R10: no done, actual 0 expected 1");
        end
        tick();
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    // {addr[6:0], rw, fast, ack_en, stretch_en, expected result[1:0]}
    localparam logic [12:0] VEC [6] = '{
        {7'h50, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1},
        {7'h3A, 1'b1, 1'b1, 1'b1, 1'b0, 2'd1},
        {7'h7F, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2},
        {7'h00, 1'b0, 1'b1, 1'b0, 1'b0, 2'd2},
        {7'h2D, 1'b0, 1'b0, 1'b1, 1'b1, 2'd1},
        {7'h55, 1'b1, 1'b1, 1'b1, 1'b1, 2'd1}
    };

    initial begin
        repeat (190000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        int n;
        logic [6:0] a; logic r, f;
        logic [1:0] keep;
        rst = 1'b1; start_i = 1'b0; addr_i = '0; rw_i = 1'b0; fast_i = 1'b0;
        repeat (4) tick();
        // R1 reset state
        chk_eq("R1 sda drive in reset", int'(sda_drive), 0);
        chk_eq("R1 scl drive in reset", int'(scl_drive), 0);
        chk_eq("R1 busy in reset", int'(busy), 0);
        chk_eq("R1 done in reset", int'(done), 0);
        chk_eq("R1 result in reset", int'(result), 0);
        rst = 1'b0;
        clear_stats();
        repeat (5) tick();
        chk_eq("R1 busy after reset", int'(busy), 0);

        // vector table
        for (int i = 0; i < 6; i++) begin
            a = VEC[i][12:6]; r = VEC[i][5]; f = VEC[i][4];
            ack_en = VEC[i][3]; stretch_en = VEC[i][2];
            clear_stats();
            launch(a, r, f);
            wait_done(n);
            chk_eq("R6 result code", int'(result), int'(VEC[i][1:0]));
            chk_eq("R4 address byte", int'(cap), int'({a, r}));
            chk_eq(f ? "R11 R3 start hold fast" : "R3 start hold", hold_meas,
                   f ? cyc_of(600) : cyc_of(4000));
            chk_eq("R5 shortest low", low_min, 2 * (f ? cyc_of(650) : cyc_of(2350)));
            chk_eq("R5 longest low", low_max, 2 * (f ? cyc_of(650) : cyc_of(2350)));
            chk_ge("R5 high after read-back", high_min, f ? cyc_of(600) : cyc_of(4000));
            chk_ge("R7 stop setup", su_meas, f ? cyc_of(600) : cyc_of(4000));
            chk_ge("R7 bus free after stop", free_meas, f ? cyc_of(1300) : cyc_of(4700));
            chk_eq("R10 single done", done_cnt, 1);
            chk_eq("R10 done width", int'(width_err), 0);
            chk_eq("R8 lines released after", int'(sda_drive | scl_drive), 0);
        end
        stretch_en = 1'b0;

        // R9: start while busy ignored
        ack_en = 1'b1;
        clear_stats();
        launch(7'h12, 1'b0, 1'b1);
        repeat (300) tick();
        launch(7'h6B, 1'b1, 1'b0);
        wait_done(n);
        chk_eq("R9 byte of first request", int'(cap), int'({7'h12, 1'b0}));
        repeat (2000) tick();
        chk_eq("R9 only one done", done_cnt, 1);
        chk_eq("R9 no second transaction", int'(busy), 0);

        // R10: result holds after done
        keep = result;
        repeat (100) tick();
        chk_eq("R10 result held", int'(result), int'(keep));

        // R2: SDA held low before start, then released
        clear_stats();
        tick(); stuck_sda = 1'b1;
        launch(7'h21, 1'b0, 1'b1);
        repeat (100) tick();
        chk_eq("R2 waiting while busy", int'(busy), 1);
        chk_eq("R2 lines released while waiting", int'(sda_drive | scl_drive), 0);
        stuck_sda = 1'b0;
        wait_done(n);
        chk_eq("R2 result after release", int'(result), 1);
        chk_ge("R2 bus free before start", pre_free, cyc_of(1300));

        // R8: SCL held low before start
        clear_stats();
        tick(); stuck_scl = 1'b1;
        launch(7'h44, 1'b0, 1'b0);
        wait_done(n);
        chk_eq("R8 stuck before start", int'(result), 3);
        chk_ge("R8 timeout length", n, TMO);
        chk_eq("R8 released after stuck", int'(sda_drive | scl_drive), 0);
        stuck_scl = 1'b0;

        // R8: SCL held low in mid-transaction, then recovery
        clear_stats();
        tick(); hang_en = 1'b1;
        launch(7'h0F, 1'b1, 1'b1);
        wait_done(n);
        chk_eq("R8 stuck mid transfer", int'(result), 3);
        chk_eq("R8 released after hang", int'(sda_drive | scl_drive), 0);
        hang_en = 1'b0;
        clear_stats();
        launch(7'h0F, 1'b1, 1'b1);
        wait_done(n);
        chk_eq("R8 recovery result", int'(result), 1);
        chk_eq("R8 recovery byte", int'(cap), int'({7'h0F, 1'b1}));

        finish_run();
    end

endmodule